// File: doc/BRIEF.md
# Eight-Channel Phase-Shifted Dimming Generator

This block produces the on/off enables for eight LED current sinks. A dimming period is divided into 256 brightness steps, each lasting a programmable number of system clocks, so the period length is set in clock counts rather than by an analog oscillator. An 8-bit brightness code sets how many of those steps each channel is lit. A 2-bit mode code picks one of four schemes: staggered turn-on, all channels together, raw pass-through of an external PWM pin, or a DC mode that holds every sink on and reports an 8-bit amplitude code instead.

A global enable gates everything and restarts the period from its first step. A per-channel fault input, driven by external open/short detection, disables a string for good: once a channel has been flagged it stays dark until the block is reset. Brightness changes are taken only at a period boundary, so a pulse is never cut short or stretched in the middle of a period.

Top module: `dim_gen_top`

## Requirements
- R1: `mode_i` selects the scheme: 0 = direct pass-through, 1 = simultaneous, 2 = staggered, 3 = DC.
- R2: One period is 256 steps and each step lasts `step_len_i` clocks, with 0 treated as 1; the step index restarts at 0 after step 255.
- R3: In modes 1 and 2 a channel is lit in the steps whose phase-relative index is below the latched brightness, so the pulse covers brightness/256 of the period; brightness 0xFF lights the channel for the whole period and 0x00 keeps it dark.
- R4: In mode 2, channel k (k = 0..7) has its phase shifted by 2·k steps: it is lit when (step − 2k) mod 256 is below the brightness, so the last channel lags the first by 14 steps.
- R5: In mode 1 every non-faulted channel switches on and off in the same cycle, with no phase shift.
- R6: In mode 0 every non-faulted enabled channel equals `pwm_i` in the same cycle, with no register and no duty extraction in the path.
- R7: In mode 3 every non-faulted channel is on continuously and `level_o` equals the latched brightness; in modes 0 to 2 `level_o` is 0xFF; while disabled `level_o` is 0.
- R8: The latched brightness takes `brightness_i` at the edge that ends step 255 of a period, and on every edge while `enable_i` is low; a change at any other time has no effect until the next period.
- R9: With `enable_i` low all of `ch_en_o` are 0, and the next enabled cycle begins at step 0, count 0.
- R10: A channel whose `fault_i` bit is high in any cycle is off from that cycle on in every mode, until `rst_ni` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable; low forces outputs off and restarts the period |
| mode_i | input | 2 | Dimming scheme code (R1) |
| brightness_i | input | 8 | Brightness code, 0x00 to 0xFF |
| step_len_i | input | 16 | Clocks per brightness step (0 acts as 1) |
| pwm_i | input | 1 | External PWM used in pass-through mode |
| fault_i | input | 8 | Per-channel fault flags, one bit per channel |
| ch_en_o | output | 8 | Current-sink enables, bit k for channel k |
| level_o | output | 8 | Amplitude code for the current sinks |

## Verification
Staggered mode is run over a full period at brightness 0x40 and 0xC0 with a one-clock step, and again at 0x40 with a two-clock step; the per-channel lag separates a correct 2-step shift from none, from one step, or from a shift measured in clocks instead of steps. Simultaneous mode at 0x00, 0x80 and 0xFF separates the threshold comparison from an off-by-one and shows the full-scale override. A brightness change in the middle of a period shows whether the new value is held back to the boundary, and a mid-period disable shows whether the phase restarts. Pass-through toggling, DC levels and a one-cycle fault pulse followed by a reset cover the remaining paths.

// File: rtl/dim_gen_pkg.sv
package dim_gen_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_SIMUL   = 2'd1,
    MODE_STAGGER = 2'd2,
    MODE_DC      = 2'd3
  } dim_mode_e;
endpackage

// File: rtl/dim_step_timer.sv
module dim_step_timer #(
  parameter int STEP_W = 16,
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [STEP_W-1:0] step_len_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              period_end_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

  logic [STEP_W-1:0] pre_q;
  logic [SLOT_W-1:0] slot_q;
  logic [STEP_W-1:0] step_last;
  logic              step_done;

  assign step_last    = (step_len_i == '0) ? '0 : step_len_i - 1'b1;
  assign step_done    = (pre_q >= step_last);
  assign period_end_o = enable_i && step_done && (slot_q == SLOT_LAST);
  assign slot_o       = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (!enable_i) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (step_done) begin
      pre_q  <= '0;
      slot_q <= slot_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  // R2: step index advances by one at each step end, wrapping at the top
  p_slot_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && step_done) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));

  // R9: disabled cycle restarts the period
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (slot_q == '0 && pre_q == '0));
endmodule

// File: rtl/dim_channel.sv
module dim_channel
  import dim_gen_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int OFFSET = 0
) (
  input  logic              enable_i,
  input  dim_mode_e         mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] brt_i,
  input  logic              pwm_i,
  input  logic              off_i,
  output logic              on_o
);
  localparam logic [SLOT_W-1:0] OFF_STEPS = SLOT_W'(OFFSET);
  localparam logic [SLOT_W-1:0] FULL      = '1;

  logic [SLOT_W-1:0] rel_stag;
  logic              hit_simul;
  logic              hit_stag;
  logic              raw;

  assign rel_stag  = slot_i - OFF_STEPS;
  assign hit_simul = (brt_i == FULL) || (slot_i < brt_i);
  assign hit_stag  = (brt_i == FULL) || (rel_stag < brt_i);

  always_comb begin
    unique case (mode_i)
      MODE_DIRECT:  raw = pwm_i;
      MODE_SIMUL:   raw = hit_simul;
      MODE_STAGGER: raw = hit_stag;
      default:      raw = 1'b1;
    endcase
  end

  assign on_o = enable_i && !off_i && raw;
endmodule

// File: rtl/dim_gen_top.sv
module dim_gen_top
  import dim_gen_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int BRT_W      = 8,
  parameter int STEP_W     = 16,
  parameter int PHASE_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [1:0]        mode_i,
  input  logic [BRT_W-1:0]  brightness_i,
  input  logic [STEP_W-1:0] step_len_i,
  input  logic              pwm_i,
  input  logic [NUM_CH-1:0] fault_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [BRT_W-1:0]  level_o
);
  localparam logic [BRT_W-1:0] FULL = '1;

  dim_mode_e         mode;
  logic [BRT_W-1:0]  slot;
  logic              period_end;
  logic [BRT_W-1:0]  brt_q;
  logic [NUM_CH-1:0] fault_q;
  logic [NUM_CH-1:0] off_mask;

  assign mode     = dim_mode_e'(mode_i);
  assign off_mask = fault_q | fault_i;

  dim_step_timer #(.STEP_W(STEP_W), .SLOT_W(BRT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .step_len_i  (step_len_i),
    .slot_o      (slot),
    .period_end_o(period_end)
  );

  // brightness sampled only at period boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      brt_q <= FULL;
    else if (!enable_i || period_end) brt_q <= brightness_i;
  end

  // sticky fault mask, cleared only by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= '0;
    else         fault_q <= fault_q | fault_i;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dim_channel #(.SLOT_W(BRT_W), .OFFSET(PHASE_STEP * k)) u_ch (
      .enable_i(enable_i),
      .mode_i  (mode),
      .slot_i  (slot),
      .brt_i   (brt_q),
      .pwm_i   (pwm_i),
      .off_i   (off_mask[k]),
      .on_o    (ch_en_o[k])
    );

    // R10: a flagged channel stays dark afterwards
    p_fault_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i[k] |=> !ch_en_o[k]);
  end

  always_comb begin
    if (!enable_i)            level_o = '0;
    else if (mode == MODE_DC) level_o = brt_q;
    else                      level_o = FULL;
  end

  // R8: latched brightness holds between period boundaries
  p_brt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !period_end) |=> $stable(brt_q));
endmodule

// File: tb/dim_gen_top_bench.sv
module dim_gen_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] mode;
  logic [7:0] brt;
  logic [15:0] step;
  logic       pwm;
  logic [7:0] fault;
  logic [7:0] ch_en;
  logic [7:0] level;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dim_gen_top u_dim_gen_top (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_i(mode),
    .brightness_i(brt), .step_len_i(step), .pwm_i(pwm), .fault_i(fault),
    .ch_en_o(ch_en), .level_o(level)
  );

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_pwm(int slot, logic [7:0] b, int shift);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rel;
      rel = 8'((slot - shift * k) & 255);
      e[k] = (b == 8'hFF) || (rel < b);
    end
    return e;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; mode = 2'd1; brt = 8'h00; step = 16'd1;
    pwm = 1'b0; fault = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // enable a fresh period with given settings; caller is at a negedge
  task automatic start(logic [1:0] m, logic [7:0] b, logic [15:0] s);
    en = 1'b0; mode = m; brt = b; step = s;
    @(negedge clk);
    en = 1'b1;
  endtask

  // R4 R2 R3: staggered phase over a whole period
  task automatic t_stagger(logic [7:0] b, logic [15:0] s);
    int stp;
    stp = (s == 0) ? 1 : int'(s);
    start(2'd2, b, s);
    for (int n = 0; n < 256 * stp; n++) begin
      #1 chk8("R4", ch_en, exp_pwm(n / stp, b, 2));
      @(negedge clk);
    end
    // R2: period wraps back to step 0
    #1 chk8("R2", ch_en, exp_pwm(0, b, 2));
    en = 1'b0;
    @(negedge clk);
  endtask

  // R5 R3: simultaneous
  task automatic t_simul(logic [7:0] b);
    start(2'd1, b, 16'd1);
    for (int n = 0; n < 256; n++) begin
      #1 chk8((b == 8'hFF || b == 8'h00) ? "R3" : "R5", ch_en, exp_pwm(n, b, 0));
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  // R8: mid-period change waits for the boundary
  task automatic t_latch();
    start(2'd1, 8'h40, 16'd1);
    for (int n = 0; n < 512; n++) begin
      if (n == 100) brt = 8'hC8;
      #1 chk8("R8", ch_en, exp_pwm(n % 256, (n < 256) ? 8'h40 : 8'hC8, 0));
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  // R9: disable forces off and restarts phase
  task automatic t_disable();
    start(2'd2, 8'h10, 16'd1);
    repeat (50) @(negedge clk);
    en = 1'b0;
    #1 chk8("R9", ch_en, 8'h00);
    chk8("R7", level, 8'h00);
    @(negedge clk);
    #1 chk8("R9", ch_en, 8'h00);
    en = 1'b1;
    for (int n = 0; n < 20; n++) begin
      #1 chk8("R9", ch_en, exp_pwm(n, 8'h10, 2));
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  // R6 R1: pass-through
  task automatic t_direct();
    start(2'd0, 8'h05, 16'd1);
    for (int n = 0; n < 12; n++) begin
      pwm = n[0] ^ n[2];
      #1 chk8("R6", ch_en, {8{pwm}});
      chk8("R7", level, 8'hFF);
      @(negedge clk);
    end
    pwm = 1'b0;
    en = 1'b0;
    @(negedge clk);
  endtask

  // R7 R1: DC mode
  task automatic t_dc(logic [7:0] b);
    start(2'd3, b, 16'd1);
    for (int n = 0; n < 40; n++) begin
      #1 chk8("R7", ch_en, 8'hFF);
      chk8("R7", level, b);
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  // R10: one-cycle fault pulse is permanent until reset
  task automatic t_fault();
    start(2'd1, 8'hFF, 16'd1);
    #1 chk8("R10", ch_en, 8'hFF);
    fault = 8'h08;
    #1 chk8("R10", ch_en, 8'hF7);
    @(negedge clk);
    fault = 8'h00;
    for (int n = 0; n < 300; n++) begin
      #1 chk8("R10", ch_en, 8'hF7);
      @(negedge clk);
    end
    mode = 2'd3;
    #1 chk8("R10", ch_en, 8'hF7);
    mode = 2'd0; pwm = 1'b1;
    #1 chk8("R10", ch_en, 8'hF7);
    do_reset();
    start(2'd1, 8'hFF, 16'd1);
    #1 chk8("R10", ch_en, 8'hFF);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    #1 chk8("R9", ch_en, 8'h00);
    chk8("R7", level, 8'h00);
    @(negedge clk);
    t_stagger(8'h40, 16'd1);
    t_stagger(8'hC0, 16'd1);
    t_stagger(8'h40, 16'd2);
    t_stagger(8'h20, 16'd0);
    t_simul(8'h80);
    t_simul(8'h00);
    t_simul(8'hFF);
    t_latch();
    t_disable();
    t_direct();
    t_dc(8'h37);
    t_dc(8'h00);
    t_fault();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule